// File: doc/BRIEF.md
# Byte Parity Generator and Checker for a Memory Interface

This block sits between a byte-wide processor data bus and a memory array that keeps one extra check bit beside every byte. A single parity reduction over nine inputs serves both directions. On a store, the eight data bits go into the reduction and the ninth input is held at zero. The odd-sum result is then the check bit to write, so every stored nine-bit word holds an even number of ones. On a fetch, the stored check bit enters as the ninth input and all nine bits are examined together.

A fetch that is qualified as valid and finds an odd count of ones sets a sticky error. The error appears on an active-low output that is meant for a non-maskable interrupt line. It stays low until the handler pulses a clear input or the block is reset, so a level-sensitive input can sample it at any time. The even-sum and odd-sum results are also brought out so that the surrounding logic can observe them directly.

Top module: `mem_parity_guard`

## Requirements
- R1: `sum_even` and `sum_odd` are complements at all times. `sum_odd` is 1 exactly when an odd number of the nine reduction inputs are 1.
- R2: The reduction inputs are the eight `bus_data` bits plus one ninth bit. The ninth bit equals `chk_in` only in a read cycle (`rd_stb`=1, `wr_stb`=0) and is 0 in every other cycle.
- R3: `chk_out` always equals `sum_odd`. In a write cycle (`wr_stb`=1, `rd_stb`=0) the nine-bit value {`chk_out`,`bus_data`} therefore has an even number of ones, whatever the value of `chk_in`.
- R4: In a read cycle where {`chk_in`,`bus_data`} holds an even number of ones, `sum_even` is 1 and no error is recorded.
- R5: A read cycle with `access_vld`=1 and `sum_even`=0 at a rising clock edge drives `parity_err_n` to 0 right after that edge.
- R6: Once `parity_err_n` is 0, it stays 0 until an edge with `err_clr`=1 and no new error. If an error and a clear occur at the same edge, the error wins.
- R7: Idle cycles, write cycles and read cycles with `access_vld`=0 never drive `parity_err_n` low, whatever the data.
- R8: `rst_n`=0 forces `parity_err_n` to 1 without waiting for a clock edge, including while an error is held.
- R9: A cycle with both strobes high is treated as no access. The ninth input is 0 and the cycle raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | DATA_W | Data byte on the processor bus |
| rd_stb | input | 1 | Read cycle in progress, active high |
| wr_stb | input | 1 | Write cycle in progress, active high |
| access_vld | input | 1 | Read data from memory is valid to check |
| chk_in | input | 1 | Check bit read back from memory |
| err_clr | input | 1 | Clears the held error at the next edge |
| chk_out | output | 1 | Check bit to store beside the byte |
| sum_even | output | 1 | 1 when the reduction inputs hold an even count of ones |
| sum_odd | output | 1 | 1 when the reduction inputs hold an odd count of ones |
| parity_err_n | output | 1 | Held parity error, active low |

## Verification
The assertions check on every cycle that the two sums are complementary and match a population count of the read inputs. They also check that a write always presents an even nine-bit word, that the error falls only after a qualified bad read, and that a held error is neither dropped without a clear nor kept after a lone clear. Only the bench scenarios can show the following, because they depend on chosen stimulus:
- `chk_in` is ignored on writes, idle cycles and strobe clashes, which is shown by toggling it against fixed data.
- An error raised at the same edge as a clear survives.
- Reset releases a held error asynchronously.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_WRITE = 2'd1,
    CYC_READ  = 2'd2,
    CYC_CLASH = 2'd3
  } cyc_kind_t;

  // Bus cycle kind from the two strobes; both high counts as no access (R9)
  function automatic cyc_kind_t classify_cycle(input logic rd, input logic wr);
    cyc_kind_t k;
    case ({rd, wr})
      2'b10:   k = CYC_READ;
      2'b01:   k = CYC_WRITE;
      2'b11:   k = CYC_CLASH;
      default: k = CYC_IDLE;
    endcase
    return k;
  endfunction

  // Ninth reduction input: the stored bit only takes part in reads (R2)
  function automatic logic ninth_input(input cyc_kind_t k, input logic stored);
    return (k == CYC_READ) ? stored : 1'b0;
  endfunction

endpackage

// File: rtl/mpg_cycle_decode.sv
module mpg_cycle_decode
  import mpg_pkg::*;
(
  input  logic      rd_stb,
  input  logic      wr_stb,
  input  logic      access_vld,
  input  logic      chk_in,
  output cyc_kind_t cyc_kind,
  output logic      ninth_bit,
  output logic      check_qual
);

  always_comb begin
    cyc_kind   = classify_cycle(rd_stb, wr_stb);
    ninth_bit  = ninth_input(cyc_kind, chk_in);
    check_qual = (cyc_kind == CYC_READ) && access_vld;
  end

endmodule

// File: rtl/mpg_xor_reduce.sv
module mpg_xor_reduce #(
  parameter int WIDTH = 9
) (
  input  logic [WIDTH-1:0] bits,
  output logic             odd
);

  localparam int LAST = WIDTH - 1;

  logic [WIDTH-1:0] prefix;

  assign prefix[0] = bits[0];

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
      assign prefix[i] = prefix[i-1] ^ bits[i];
    end
  endgenerate

  assign odd = prefix[LAST];

endmodule

// File: rtl/mpg_err_hold.sv
module mpg_err_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic err_q
);

  // New error has priority over a clear at the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (set_req) err_q <= 1'b1;
    else if (clr_req) err_q <= 1'b0;
  end

endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              access_vld,
  input  logic              chk_in,
  input  logic              err_clr,
  output logic              chk_out,
  output logic              sum_even,
  output logic              sum_odd,
  output logic              parity_err_n
);

  localparam int TREE_W = DATA_W + 1;

  cyc_kind_t         cyc_kind;
  logic              ninth_bit;
  logic              check_qual;
  logic [TREE_W-1:0] tree_in;
  logic              tree_odd;
  logic              bad_read;
  logic              err_q;

  mpg_cycle_decode u_dec (
    .rd_stb     (rd_stb),
    .wr_stb     (wr_stb),
    .access_vld (access_vld),
    .chk_in     (chk_in),
    .cyc_kind   (cyc_kind),
    .ninth_bit  (ninth_bit),
    .check_qual (check_qual)
  );

  assign tree_in = {ninth_bit, bus_data};

  mpg_xor_reduce #(.WIDTH(TREE_W)) u_tree (
    .bits (tree_in),
    .odd  (tree_odd)
  );

  assign sum_odd  = tree_odd;
  assign sum_even = ~tree_odd;
  assign chk_out  = tree_odd;

  // Qualified read whose nine bits hold an odd count
  assign bad_read = check_qual & tree_odd;

  mpg_err_hold u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (bad_read),
    .clr_req (err_clr),
    .err_q   (err_q)
  );

  assign parity_err_n = ~err_q;

endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              access_vld,
  input logic              chk_in,
  input logic              err_clr,
  input logic              chk_out,
  input logic              sum_even,
  input logic              sum_odd,
  input logic              parity_err_n
);

  assert_sums_complement_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sum_even != sum_odd);

  assert_read_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb) |-> (sum_odd == ($countones({chk_in, bus_data}) % 2 == 1)));

  assert_write_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb) |-> ($countones({chk_out, bus_data}) % 2 == 0));

  assert_good_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && ($countones({chk_in, bus_data}) % 2 == 0)) |-> sum_even);

  assert_bad_read_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && access_vld && !sum_even) |=> !parity_err_n);

  assert_error_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!parity_err_n && !err_clr) |=> !parity_err_n);

  assert_clear_releases_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(rd_stb && !wr_stb && access_vld && !sum_even)) |=> parity_err_n);

  assert_fall_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(parity_err_n) |-> $past(rd_stb && !wr_stb && access_vld && sum_odd));

  assert_clash_no_ninth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && wr_stb) |-> (sum_odd == ($countones(bus_data) % 2 == 1)));

endmodule

bind mem_parity_guard mpg_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/mem_parity_guard_test.sv
module mem_parity_guard_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic  exp_odd;
    logic  exp_err_n;
    string tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic       rd_stb = 1'b0;
  logic       wr_stb = 1'b0;
  logic       access_vld = 1'b0;
  logic       chk_in = 1'b0;
  logic       err_clr = 1'b0;
  logic       chk_out, sum_even, sum_odd, parity_err_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic model_err = 1'b0;
  exp_item_t sb[$];

  mem_parity_guard #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .access_vld(access_vld), .chk_in(chk_in),
    .err_clr(err_clr), .chk_out(chk_out), .sum_even(sum_even),
    .sum_odd(sum_odd), .parity_err_n(parity_err_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int count_ones(input logic [7:0] d);
    int c = 0;
    for (int i = 0; i < 8; i++) if (d[i]) c++;
    return c;
  endfunction

  task automatic check1(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(input logic [7:0] d, input logic rd, input logic wr,
                      input logic vld, input logic ci, input logic clr, input string tag);
    exp_item_t it;
    logic is_read;
    int ones;
    @(negedge clk);
    bus_data = d; rd_stb = rd; wr_stb = wr; access_vld = vld; chk_in = ci; err_clr = clr;
    is_read = rd && !wr;
    ones = count_ones(d) + ((is_read && ci) ? 1 : 0);
    it.exp_odd = (ones % 2) == 1;
    if (is_read && vld && it.exp_odd) model_err = 1'b1;
    else if (clr) model_err = 1'b0;
    it.exp_err_n = !model_err;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_item_t it;
        it = sb.pop_front();
        check1(it.tag, "sum_odd", sum_odd, it.exp_odd);
        check1(it.tag, "sum_even", sum_even, !it.exp_odd);
        check1(it.tag, "chk_out", chk_out, it.exp_odd);
        check1(it.tag, "parity_err_n", parity_err_n, it.exp_err_n);
      end
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    #(CLK_PERIOD*2 + 1);
    check1("R8", "reset parity_err_n", parity_err_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;

    // R3/R2: writes with chk_in toggled against fixed data
    step(8'h00, 0, 1, 1, 1, 0, "R3");
    step(8'hFF, 0, 1, 1, 0, 0, "R3");
    step(8'h01, 0, 1, 1, 0, 0, "R3");
    step(8'h01, 0, 1, 1, 1, 0, "R2");
    step(8'hA5, 0, 1, 0, 1, 0, "R3");
    step(8'h7F, 0, 1, 1, 1, 0, "R3");
    // R1/R4: good reads
    step(8'h7F, 1, 0, 1, 1, 0, "R4");
    step(8'h00, 1, 0, 1, 0, 0, "R4");
    step(8'h80, 1, 0, 1, 1, 0, "R1");
    // R7: bad data but not qualified
    step(8'h80, 1, 0, 0, 0, 0, "R7");
    step(8'h13, 0, 0, 1, 1, 0, "R7");
    step(8'h13, 0, 1, 1, 1, 0, "R7");
    // R9: both strobes, stored bit ignored
    step(8'h03, 1, 1, 1, 1, 0, "R9");
    step(8'h07, 1, 1, 1, 0, 0, "R9");
    // R5: qualified bad read
    step(8'hC3, 1, 0, 1, 1, 0, "R5");
    // R6: hold, then clear together with new error, then clear alone
    step(8'h00, 0, 0, 0, 0, 0, "R6");
    step(8'h55, 0, 1, 1, 0, 0, "R6");
    step(8'h01, 1, 0, 1, 0, 1, "R6");
    step(8'h00, 0, 0, 0, 0, 0, "R6");
    step(8'h00, 0, 0, 0, 0, 1, "R6");
    step(8'h00, 0, 0, 0, 0, 0, "R6");
    // R5 again, then R8 asynchronous release
    step(8'hFE, 1, 0, 1, 0, 0, "R5");
    step(8'h00, 0, 0, 0, 0, 0, "R5");
    @(negedge clk);
    rst_n = 1'b0;
    model_err = 1'b0;
    #1;
    check1("R8", "async reset parity_err_n", parity_err_n, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    step(8'h00, 0, 0, 0, 0, 0, "R8");
    step(8'h00, 0, 0, 0, 0, 0, "R8");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule